// File: doc/BRIEF.md
# Banked ROM Socket Select Controller

This block is the control logic of a ROM expansion card that holds up to eight ROM sockets behind one virtual module. Software owns a single control byte that lives at the same local I/O location as the module's identification register: a write lands in the control byte, while a read at that location returns a fixed identification code. The top bit of the control byte enables the card. The low three bits point at one socket.

When the card is enabled, a memory read that falls inside the card's memory window raises the chip select of the pointed socket, provided that socket is populated. The selected ROM's byte is then returned. When no socket drives the bus, the returned byte is the value the bus last held. Any local I/O read, such as the identification read, leaves that held value at zero. Software detects an empty socket by reading the identification register, selecting the socket, and reading memory offset 0. Every installed ROM begins with a nonzero byte, so a zero result means the socket is empty.

Top module: `rom_bank_sel`

## Requirements
- R1: After reset the control byte is zero, so no chip select is raised and `rd_data` reads 0 during a memory read in the window.
- R2: A write with `io_lo_en` high to word `{VM_IDX,3'b000}` of the local I/O space loads `wr_data` into the control byte at that clock edge. A read of that location returns `ID_CODE`, not the control byte.
- R3: With control bit 7 at 0, no chip select is raised for any memory read, whatever bits 2..0 hold.
- R4: With control bit 7 at 1, a memory read (`mem_space`=1, `rd_stb`=1) whose address bits above `WIN_W` equal `WIN_BASE` raises exactly `rom_sel[bits 2..0]`. At most one chip select is ever high.
- R5: No chip select is raised for I/O-space cycles, for addresses outside the window, or without a read strobe.
- R6: Writing zero to every local word (the boot clear) leaves the module disabled. Writes to other local words, or writes with `io_lo_en` low, leave the control byte unchanged.
- R7: A socket index at or above `NUM_POP` is never selected, even when the control byte points at it.
- R8: During a selected read, `rd_data` equals the byte that the selected socket presents on `sock_data[8*i +: 8]`.
- R9: After any local I/O read, a memory read that no socket drives returns 0.
- R10: A memory read that no socket drives returns the byte driven in the last driven read, if no local I/O read came between the two.
- R11: Writes with `io_sel` low, or to the other virtual module's half (`io_word[3]` != `VM_IDX`), have no effect on the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_sel | input | 1 | Slot's local I/O space selected |
| io_word | input | 4 | Local word address; bit 3 picks the virtual module |
| io_lo_en | input | 1 | Access includes the low byte lane |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_data | input | 8 | Low-lane write data |
| mem_space | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| mem_addr | input | ADDR_W | Memory address |
| sock_data | input | 8*SOCKETS | Byte presented by each socket, socket i at bits 8*i+7..8*i |
| rom_sel | output | SOCKETS | Per-socket chip select, active high |
| rd_data | output | 8 | Read data returned by the card |

## Verification
The bench builds the block with `NUM_POP` = 5 and `VM_IDX` = 1. Five populated sockets leave indices 5 to 7 pointable but empty, so the bench can run the empty-socket detection sequence and the stale-hold case on a real unpopulated index. Placing the module in the upper half of the slot makes writes to the lower half a meaningful decoy. A 64 KiB window at base 0xC lets the bench probe the addresses just below and above the window edges.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam int BYTE_W = 8;
   localparam int BANK_W = 3;

   typedef logic [BYTE_W-1:0] byte_t;

   // Stored part of the control byte: bit 7 enable, bits 2..0 socket.
   typedef struct packed {
      logic              en;
      logic [BANK_W-1:0] bank;
   } ctrl_t;

   function automatic ctrl_t ctrl_from_byte(input byte_t b);
      ctrl_t c;
      c.en   = b[BYTE_W-1];
      c.bank = b[BANK_W-1:0];
      return c;
   endfunction
endpackage

// File: rtl/rbs_ctrl_reg.sv
module rbs_ctrl_reg
   import rbs_pkg::*;
#(
   parameter int VM_IDX = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        io_sel,
   input  logic [3:0]  io_word,
   input  logic        io_lo_en,
   input  logic        rd_stb,
   input  logic        wr_stb,
   input  byte_t       wr_data,
   output ctrl_t       ctrl_q,
   output logic        local_rd,
   output logic        id_rd
);
   localparam logic VM_BIT = 1'(VM_IDX);

   logic local_hit;
   logic ctrl_hit;
   logic ctrl_wr;

   assign local_hit = io_sel && (io_word[3] == VM_BIT);
   assign ctrl_hit  = local_hit && (io_word[2:0] == 3'd0) && io_lo_en;
   assign ctrl_wr   = ctrl_hit && wr_stb;
   assign local_rd  = local_hit && rd_stb;
   assign id_rd     = ctrl_hit && rd_stb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_from_byte(wr_data);
      end
   end

   logic unused_wr;
   assign unused_wr = ^wr_data[BYTE_W-2:BANK_W];
endmodule

// File: rtl/rbs_sock_dec.sv
module rbs_sock_dec
   import rbs_pkg::*;
#(
   parameter int ADDR_W   = 20,
   parameter int WIN_W    = 16,
   parameter int WIN_BASE = 12,
   parameter int SOCKETS  = 8,
   parameter int NUM_POP  = 8
) (
   input  ctrl_t               ctrl_q,
   input  logic                mem_space,
   input  logic [ADDR_W-1:0]   mem_addr,
   input  logic                rd_stb,
   output logic [SOCKETS-1:0]  rom_sel,
   output logic                drv
);
   localparam int TAG_W = ADDR_W - WIN_W;
   localparam logic [TAG_W-1:0] TAG = TAG_W'(WIN_BASE);

   logic win_rd;
   assign win_rd = ctrl_q.en && mem_space && rd_stb &&
                   (mem_addr[ADDR_W-1:WIN_W] == TAG);

   for (genvar s = 0; s < SOCKETS; s++) begin : g_sock
      if (s < NUM_POP) begin : g_pop
         assign rom_sel[s] = win_rd && (ctrl_q.bank == BANK_W'(s));
      end else begin : g_empty
         assign rom_sel[s] = 1'b0;
      end
   end

   assign drv = |rom_sel;

   logic unused_low;
   assign unused_low = ^mem_addr[WIN_W-1:0];
endmodule

// File: rtl/rbs_data_path.sv
module rbs_data_path
   import rbs_pkg::*;
#(
   parameter int     SOCKETS = 8,
   parameter logic [7:0] ID_CODE = 8'h3C
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     local_rd,
   input  logic                     id_rd,
   input  logic                     drv,
   input  logic [BANK_W-1:0]        bank,
   input  logic [BYTE_W*SOCKETS-1:0] sock_data,
   output byte_t                    rd_data
);
   byte_t sock_byte [SOCKETS];
   byte_t hold_q;
   byte_t pick;

   for (genvar s = 0; s < SOCKETS; s++) begin : g_lane
      assign sock_byte[s] = sock_data[BYTE_W*s +: BYTE_W];
   end

   always_comb begin
      pick = hold_q;
      for (int s = 0; s < SOCKETS; s++) begin
         if (bank == BANK_W'(s)) pick = sock_byte[s];
      end
   end

   always_comb begin
      if (id_rd)         rd_data = ID_CODE;
      else if (local_rd) rd_data = '0;
      else if (drv)      rd_data = pick;
      else               rd_data = hold_q;
   end

   // Bus keeper: zeroed by any local read, follows any socket-driven read.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (local_rd) begin
         hold_q <= '0;
      end else if (drv) begin
         hold_q <= pick;
      end
   end
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel
   import rbs_pkg::*;
#(
   parameter int         ADDR_W   = 20,
   parameter int         WIN_W    = 16,
   parameter int         WIN_BASE = 12,
   parameter int         NUM_POP  = 8,
   parameter int         VM_IDX   = 0,
   parameter logic [7:0] ID_CODE  = 8'h3C
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      io_sel,
   input  logic [3:0]                io_word,
   input  logic                      io_lo_en,
   input  logic                      rd_stb,
   input  logic                      wr_stb,
   input  logic [7:0]                wr_data,
   input  logic                      mem_space,
   input  logic [ADDR_W-1:0]         mem_addr,
   input  logic [8*(1<<3)-1:0]       sock_data,
   output logic [(1<<3)-1:0]         rom_sel,
   output logic [7:0]                rd_data
);
   localparam int SOCKETS = 1 << BANK_W;

   initial begin
      if (NUM_POP < 1 || NUM_POP > SOCKETS)
         $error("rom_bank_sel: NUM_POP out of range");
      if (WIN_W < 1 || WIN_W >= ADDR_W)
         $error("rom_bank_sel: WIN_W must lie inside ADDR_W");
      if (VM_IDX < 0 || VM_IDX > 1)
         $error("rom_bank_sel: VM_IDX must be 0 or 1");
      if (ID_CODE == 8'h00)
         $error("rom_bank_sel: ID_CODE must be nonzero");
   end

   ctrl_t ctrl_q;
   logic  local_rd;
   logic  id_rd;
   logic  drv;

   rbs_ctrl_reg #(.VM_IDX(VM_IDX)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_sel   (io_sel),
      .io_word  (io_word),
      .io_lo_en (io_lo_en),
      .rd_stb   (rd_stb),
      .wr_stb   (wr_stb),
      .wr_data  (wr_data),
      .ctrl_q   (ctrl_q),
      .local_rd (local_rd),
      .id_rd    (id_rd)
   );

   rbs_sock_dec #(
      .ADDR_W   (ADDR_W),
      .WIN_W    (WIN_W),
      .WIN_BASE (WIN_BASE),
      .SOCKETS  (SOCKETS),
      .NUM_POP  (NUM_POP)
   ) u_dec (
      .ctrl_q    (ctrl_q),
      .mem_space (mem_space),
      .mem_addr  (mem_addr),
      .rd_stb    (rd_stb),
      .rom_sel   (rom_sel),
      .drv       (drv)
   );

   rbs_data_path #(
      .SOCKETS (SOCKETS),
      .ID_CODE (ID_CODE)
   ) u_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .local_rd  (local_rd),
      .id_rd     (id_rd),
      .drv       (drv),
      .bank      (ctrl_q.bank),
      .sock_data (sock_data),
      .rd_data   (rd_data)
   );
endmodule

// File: rtl/rom_bank_sel_chk.sv
module rom_bank_sel_chk #(
   parameter int NUM_POP = 8,
   parameter int VM_IDX  = 0
) (
   input logic       clk,
   input logic       rst_n,
   input logic       io_sel,
   input logic [3:0] io_word,
   input logic       wr_stb,
   input logic       mem_space,
   input logic       rd_stb,
   input logic [3:0] ctrl_bits,
   input logic [7:0] rom_sel
);
   logic ctrl_en;
   assign ctrl_en = ctrl_bits[3];

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rom_sel)); // R4
   AST_DIS_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> (rom_sel == 8'h00)); // R3
   AST_IO_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_space && rd_stb) |-> (rom_sel == 8'h00)); // R5
   AST_UNPOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((rom_sel >> NUM_POP) == 8'h00)); // R7
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_sel && wr_stb && io_word[3] == 1'(VM_IDX)) |=> $stable(ctrl_bits)); // R11
endmodule

bind rom_bank_sel rom_bank_sel_chk #(.NUM_POP(NUM_POP), .VM_IDX(VM_IDX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .io_sel    (io_sel),
   .io_word   (io_word),
   .wr_stb    (wr_stb),
   .mem_space (mem_space),
   .rd_stb    (rd_stb),
   .ctrl_bits (ctrl_q),
   .rom_sel   (rom_sel)
);

// File: tb/sim_rom_bank_sel.sv
`timescale 1ns/1ps
module sim_rom_bank_sel;
   localparam int NPOP = 5;
   localparam int VM   = 1;
   localparam logic [7:0] IDC = 8'h3C;
   localparam logic [19:0] WIN0 = 20'hC0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_sel = 1'b0;
   logic [3:0]  io_word = '0;
   logic        io_lo_en = 1'b0;
   logic        rd_stb = 1'b0;
   logic        wr_stb = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        mem_space = 1'b0;
   logic [19:0] mem_addr = '0;
   logic [63:0] sock_data;
   logic [7:0]  rom_sel;
   logic [7:0]  rd_data;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   for (genvar i = 0; i < 8; i++) begin : g_rom
      assign sock_data[8*i +: 8] = 8'(8'h11 * (i + 1));
   end

   rom_bank_sel #(.NUM_POP(NPOP), .VM_IDX(VM), .ID_CODE(IDC)) u0 (
      .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .io_word(io_word),
      .io_lo_en(io_lo_en), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
      .mem_space(mem_space), .mem_addr(mem_addr), .sock_data(sock_data),
      .rom_sel(rom_sel), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic io_wr(input logic sel, input logic [3:0] w, input logic lo, input logic [7:0] d);
      @(negedge clk);
      io_sel = sel; io_word = w; io_lo_en = lo; wr_data = d; wr_stb = 1'b1; mem_space = 1'b0;
      @(negedge clk);
      io_sel = 1'b0; wr_stb = 1'b0; io_lo_en = 1'b0;
   endtask

   task automatic io_rd(output logic [7:0] d);
      @(negedge clk);
      io_sel = 1'b1; io_word = {1'(VM), 3'd0}; io_lo_en = 1'b1; rd_stb = 1'b1; mem_space = 1'b0;
      #2 d = rd_data;
      @(negedge clk);
      io_sel = 1'b0; rd_stb = 1'b0; io_lo_en = 1'b0;
   endtask

   task automatic mem_rd(input logic ms, input logic stb, input logic [19:0] a,
                         output logic [7:0] sel, output logic [7:0] d);
      @(negedge clk);
      mem_space = ms; mem_addr = a; rd_stb = stb;
      #2 sel = rom_sel; d = rd_data;
      @(negedge clk);
      mem_space = 1'b0; rd_stb = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] s, d;
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R1 sel after reset", s, 8'h00);
      check("R1 data after reset", d, 8'h00);
   endtask

   task automatic t_id_and_select();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h82);
      io_rd(d);
      check("R2 id read", d, IDC);
      mem_rd(1'b1, 1'b1, WIN0 + 20'h0123, s, d);
      check("R4 sel bank2", s, 8'h04);
      check("R8 data bank2", d, 8'h33);
   endtask

   task automatic t_all_banks();
      logic [7:0] s, d;
      for (int i = 0; i < NPOP; i++) begin
         io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h80 | 8'(i));
         mem_rd(1'b1, 1'b1, WIN0 + 20'hFFFF, s, d);
         check("R4 sel sweep", s, 8'(1 << i));
         check("R8 data sweep", d, 8'(8'h11 * (i + 1)));
      end
   endtask

   task automatic t_outside();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h81);
      mem_rd(1'b1, 1'b1, 20'hBFFFF, s, d);
      check("R5 below window", s, 8'h00);
      mem_rd(1'b1, 1'b1, 20'hD0000, s, d);
      check("R5 above window", s, 8'h00);
      mem_rd(1'b0, 1'b1, WIN0, s, d);
      check("R5 io space", s, 8'h00);
      mem_rd(1'b1, 1'b0, WIN0, s, d);
      check("R5 no strobe", s, 8'h00);
   endtask

   task automatic t_disabled();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h02);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R3 bit7 clear bank2", s, 8'h00);
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h7D);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R3 bit7 clear other bits", s, 8'h00);
   endtask

   task automatic t_empty_socket();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h83);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R8 data bank3", d, 8'h44);
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h86);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R7 unpopulated sel", s, 8'h00);
      check("R10 stale hold", d, 8'h44);
      io_rd(d);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R9 empty reads zero", d, 8'h00);
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h87);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R7 socket7 sel", s, 8'h00);
   endtask

   task automatic t_ignored_writes();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h81);
      io_wr(1'b1, {1'(VM), 3'd3}, 1'b1, 8'h85);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R6 other word", s, 8'h02);
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b0, 8'h00);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R6 low lane off", s, 8'h02);
      io_wr(1'b1, {1'(1 - VM), 3'd0}, 1'b1, 8'h00);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R11 other half", s, 8'h02);
      io_wr(1'b0, {1'(VM), 3'd0}, 1'b1, 8'h00);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R11 io_sel low", s, 8'h02);
   endtask

   task automatic t_boot_clear();
      logic [7:0] s, d;
      io_wr(1'b1, {1'(VM), 3'd0}, 1'b1, 8'h84);
      for (int w = 0; w < 8; w++) io_wr(1'b1, {1'(VM), 3'(w)}, 1'b1, 8'h00);
      mem_rd(1'b1, 1'b1, WIN0, s, d);
      check("R6 boot clear disables", s, 8'h00);
   endtask

   initial begin
      #5000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_id_and_select();
      t_all_banks();
      t_outside();
      t_disabled();
      t_empty_socket();
      t_ignored_writes();
      t_boot_clear();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule